// File: doc/BRIEF.md
# Serial Display Byte Transmitter

This block sends single bytes to a small display controller over a four-wire synchronous serial link. The link has four lines: an active-low chip select, a serial clock, a serial data line and a register-select line. The register-select line tells the receiver whether the byte is an instruction or display data. The host side gives a byte, a data/instruction flag and a one-cycle start strobe. The block answers with a busy level and a one-cycle done pulse.

A transfer has three parts. First comes a setup phase in which all four lines are driven low. Next come eight clock pulses that carry the byte most significant bit first. The data line changes while the clock is low, and the receiver latches it on each rising clock edge. Last, all four lines return high, which is the idle level of the bus. A divider input sets how many system clocks each clock phase lasts. The divider value and the byte are captured when a transfer is accepted.

Top module: `disp_ser_tx`

## Requirements
- R1: Out of reset and whenever no transfer is in progress, `cs_no`, `sck_o`, `sda_o` and `dsel_o` are all 1, and `busy_o` and `done_o` are 0.
- R2: A `start_i` sampled while idle is accepted. From the next cycle, all four serial lines are 0 for a setup phase of `div_i+1` cycles.
- R3: Each transfer has exactly eight rising edges of `sck_o`, all while `cs_no` is 0. At these edges `sda_o` carries bits 7 down to 0 of the captured byte, in that order.
- R4: Every clock-low phase and every clock-high phase lasts `div_i+1` system clocks, using the `div_i` value sampled with the accepted start.
- R5: With `is_data_i`=1, `dsel_o` is 1 at every rising edge of `sck_o`. With `is_data_i`=0, `dsel_o` stays 0 for the whole time `cs_no` is 0.
- R6: `busy_o` is 1 from the cycle after an accepted start until `cs_no` returns to 1. A `start_i` that arrives while busy is ignored: it changes neither the byte in flight nor starts a later transfer.
- R7: `done_o` is a one-cycle pulse in the first cycle that `cs_no` is back at 1. That cycle begins 17*(`div_i`+1) clock edges after the edge that accepted the start.
- R8: `sda_o` and `dsel_o` do not change while `sck_o` is 1 during a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W | Phase length minus one, in system clocks |
| start_i | input | 1 | Start strobe, one cycle |
| is_data_i | input | 1 | 1 = data register, 0 = instruction register |
| byte_i | input | DATA_W | Byte to send |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse when the transfer ends |
| cs_no | output | 1 | Chip select, active low |
| sck_o | output | 1 | Serial clock |
| sda_o | output | 1 | Serial data |
| dsel_o | output | 1 | Register-select line |

## Verification
The outputs are decoded from registers, so the setup level appears one cycle after the accepting edge. The eight clock pulses follow in phases of `div_i+1` cycles, and `done_o` rises 17*(`div_i`+1) edges after the start. Each scenario task drives its stimulus at a falling edge and then samples at every later falling edge, numbering those samples. It compares the number of the done sample with 17*(D+1)+1, and the number of clock-low samples before the first rise with 2*(D+1). It measures every high phase against D+1 and reads the bits and the select level at the samples where the clock has just risen.

// File: rtl/disp_ser_pkg.sv
package disp_ser_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_LOW   = 2'd2,
    ST_HIGH  = 2'd3
  } tx_state_e;
endpackage

// File: rtl/disp_ser_phase_timer.sv
module disp_ser_phase_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      div_q <= div_i;
      cnt_q <= '0;
    end else if (run_i) begin
      cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/disp_ser_shreg.sv
module disp_ser_shreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              shift_i,
  output logic              msb_o
);
  logic [DATA_W-1:0] sh_q;

  assign msb_o = sh_q[DATA_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '1;
    else if (load_i)  sh_q <= data_i;
    else if (shift_i) sh_q <= {sh_q[DATA_W-2:0], 1'b1};
  end
endmodule

// File: rtl/disp_ser_ctrl.sv
module disp_ser_ctrl
  import disp_ser_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  logic      tick_i,
  output tx_state_e state_o,
  output logic      load_o,
  output logic      shift_o,
  output logic      done_o
);
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  tx_state_e        state_q, state_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             done_q, done_d;

  assign state_o = state_q;
  assign done_o  = done_q;
  assign load_o  = (state_q == ST_IDLE) && start_i;
  assign shift_o = (state_q == ST_HIGH) && tick_i && (bit_q != '0);

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_SETUP;
      ST_SETUP: if (tick_i) begin
        state_d = ST_LOW;
        bit_d   = LAST_BIT;
      end
      ST_LOW:   if (tick_i) state_d = ST_HIGH;
      ST_HIGH:  if (tick_i) begin
        if (bit_q == '0) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          state_d = ST_LOW;
          bit_d   = bit_q - 1'b1;
        end
      end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      done_q  <= done_d;
    end
  end
endmodule

// File: rtl/disp_ser_tx.sv
module disp_ser_tx
  import disp_ser_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              start_i,
  input  logic              is_data_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              cs_no,
  output logic              sck_o,
  output logic              sda_o,
  output logic              dsel_o
);
  tx_state_e state;
  logic      load, shift, tick, msb, sel_q;

  disp_ser_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .tick_i  (tick),
    .state_o (state),
    .load_o  (load),
    .shift_o (shift),
    .done_o  (done_o)
  );

  disp_ser_phase_timer #(.DIV_W(DIV_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .run_i  (state != ST_IDLE),
    .div_i  (div_i),
    .tick_o (tick)
  );

  disp_ser_shreg #(.DATA_W(DATA_W)) u_shreg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .data_i  (byte_i),
    .shift_i (shift),
    .msb_o   (msb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sel_q <= 1'b0;
    else if (load) sel_q <= is_data_i;
  end

  assign busy_o = (state != ST_IDLE);

  // line levels per phase; data changes only while the clock is low
  always_comb begin
    unique case (state)
      ST_IDLE:  {cs_no, sck_o, sda_o, dsel_o} = 4'b1111;
      ST_SETUP: {cs_no, sck_o, sda_o, dsel_o} = 4'b0000;
      ST_LOW:   {cs_no, sck_o, sda_o, dsel_o} = {1'b0, 1'b0, msb, sel_q};
      ST_HIGH:  {cs_no, sck_o, sda_o, dsel_o} = {1'b0, 1'b1, msb, sel_q};
      default:  {cs_no, sck_o, sda_o, dsel_o} = 4'b1111;
    endcase
  end
endmodule

module disp_ser_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic done_o,
  input logic cs_no,
  input logic sck_o,
  input logic sda_o,
  input logic dsel_o
);
  // R1
  idle_lines_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (cs_no && sck_o && sda_o && dsel_o));
  // R6
  cs_low_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> busy_o);
  // R3
  sck_rise_selected_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sck_o) |-> !cs_no);
  // R7
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7
  done_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && cs_no && $past(busy_o)));
  // R8
  sda_hold_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && $past(sck_o) && !cs_no) |-> ($stable(sda_o) && $stable(dsel_o)));
endmodule

bind disp_ser_tx disp_ser_tx_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .busy_o (busy_o),
  .done_o (done_o),
  .cs_no  (cs_no),
  .sck_o  (sck_o),
  .sda_o  (sda_o),
  .dsel_o (dsel_o)
);

// File: tb/disp_ser_tx_bench.sv
module disp_ser_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] div = '0;
  logic       start = 1'b0;
  logic       is_data = 1'b0;
  logic [7:0] byte_v = '0;
  logic       busy, done, cs_n, sck, sda, dsel;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_ser_tx u_disp_ser_tx (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .div_i     (div),
    .start_i   (start),
    .is_data_i (is_data),
    .byte_i    (byte_v),
    .busy_o    (busy),
    .done_o    (done),
    .cs_no     (cs_n),
    .sck_o     (sck),
    .sda_o     (sda),
    .dsel_o    (dsel)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    chk({cs_n, sck, sda, dsel} == 4'b1111, req, {cs_n, sck, sda, dsel}, 15);
    chk(!busy && !done, req, {busy, done}, 0);
  endtask

  // one transfer; optional start pulse with a different byte while busy
  task automatic run_xfer(input logic [7:0] b, input bit f, input logic [7:0] d, input bit inject);
    int  k, done_k, rises, lead_low, hi_len, hi_min, hi_max, ph;
    logic [7:0] cap;
    bit  prev_sck, seen_rise, dsel_bad, setup_bad, busy_bad, sda_moved;
    logic prev_sda;
    ph = int'(d) + 1;
    @(negedge clk);
    div = d; is_data = f; byte_v = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // sample k=1: first cycle after accepting edge
    chk({cs_n, sck, sda, dsel} == 4'b0000, "R2 setup lines low", {cs_n, sck, sda, dsel}, 0);
    k = 1; done_k = 0; rises = 0; lead_low = 0; hi_len = 0;
    hi_min = 1 << 20; hi_max = 0; cap = '0; prev_sck = sck; prev_sda = sda;
    seen_rise = 0; dsel_bad = 0; setup_bad = 0; busy_bad = 0; sda_moved = 0;
    while (k < 20000) begin
      if (done) begin
        done_k = k;
        if (hi_len > 0) begin
          if (hi_len < hi_min) hi_min = hi_len;
          if (hi_len > hi_max) hi_max = hi_len;
        end
        break;
      end
      if (!busy) busy_bad = 1;
      if (!cs_n) begin
        if (k <= ph && {sck, sda, dsel} != 3'b000) setup_bad = 1;
        if (!f && dsel) dsel_bad = 1;
        if (!seen_rise && !sck) lead_low++;
        if (sck && !prev_sck) begin
          seen_rise = 1;
          rises++;
          cap = {cap[6:0], sda};
          if (f && !dsel) dsel_bad = 1;
        end
        if (sck && prev_sck && sda !== prev_sda) sda_moved = 1;
        if (sck) hi_len++;
        if (!sck && prev_sck) begin
          if (hi_len < hi_min) hi_min = hi_len;
          if (hi_len > hi_max) hi_max = hi_len;
          hi_len = 0;
        end
      end
      prev_sck = sck; prev_sda = sda;
      if (inject && k == 5) begin start = 1'b1; byte_v = ~b; is_data = ~f; end
      if (inject && k == 6) start = 1'b0;
      @(negedge clk);
      k++;
    end
    chk(!setup_bad, "R2 setup phase all low", setup_bad, 0);
    chk(lead_low == 2*ph, "R4 setup+first low length", lead_low, 2*ph);
    chk(rises == 8, "R3 eight clock rises", rises, 8);
    chk(cap == b, "R3 bits MSB first", cap, b);
    chk(hi_min == ph && hi_max == ph, "R4 high phase length", hi_max, ph);
    chk(!dsel_bad, "R5 select level", dsel_bad, 0);
    chk(!sda_moved, "R8 data stable while clock high", sda_moved, 0);
    chk(!busy_bad, "R6 busy during transfer", busy_bad, 0);
    chk(done_k == 17*ph + 1, "R7 done timing", done_k, 17*ph + 1);
    chk(cs_n && !busy, "R7 done with cs high", {cs_n, busy}, 2);
    @(negedge clk);
    chk(!done, "R7 done one cycle", done, 0);
    check_idle("R1 idle after transfer");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!busy && cs_n, "R6 no queued transfer", busy, 0);
    end
  endtask

  task automatic test_reset();
    check_idle("R1 reset state");
  endtask

  initial begin
    for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=0", WATCHDOG);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    test_reset();
    run_xfer(8'hA5, 1'b1, 8'd0, 1'b0);
    run_xfer(8'h3C, 1'b0, 8'd2, 1'b0);
    run_xfer(8'h81, 1'b1, 8'd1, 1'b1);   // R6 ignored start
    run_xfer(8'hFF, 1'b0, 8'd3, 1'b0);
    run_xfer(8'h00, 1'b1, 8'd0, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule